// File: doc/BRIEF.md
# Weekly and Daily Alarm Matcher

This block keeps two alarm channels and compares each against the running BCD time of day. The weekly channel holds a minute, an hour and a seven-bit day mask, so a single setting can fire on any chosen set of weekdays. The daily channel holds only a minute and an hour and fires every day. Each channel has its own enable bit, a sticky flag and its own active-low alarm output.

The timekeeping logic drives the current minute, hour and day code, plus a one-cycle strobe each time the minute changes. All logic runs on the 32.768 kHz clock. A match is judged only on the minute strobe. When a match is found on an enabled channel, that channel's flag is set two clock cycles later. Software writes the alarm settings through a small write port, reads them back on a combinational read port, and clears a flag by writing 0 to its bit.

Top module: `alarm_matcher`

## Requirements
- R1: After synchronous reset both alarm outputs are high, and every register (settings, enables, flags) reads 0.
- R2: The weekly channel matches when cur_min equals its minute, the hour matches, and bit cur_dow of its day mask is 1. Day code d (0 to 6) selects mask bit d, so any subset of days can be chosen.
- R3: The daily channel compares only minute and hour and matches on every day code.
- R4: Hours compare in the format chosen by mode_24h. When it is 0 (12-hour), bit 5 is PM, bit 4 is the tens digit and bits 3:0 are the units, so 12 AM (0x12) and 12 PM (0x32) differ. When it is 1 (24-hour), bits 5:4 are the tens digit.
- R5: A match sampled with min_tick at clock edge E sets the flag at edge E+2, and the output goes low then. It is still high after edge E+1.
- R6: A flag sets only while its enable bit is 1. Writing 0 to the enable bit clears that flag at the same edge, so the output goes high and the flag reads 0.
- R7: Writing 0 to a flag bit clears that flag and releases its output at the next edge. Writing 1 to a flag bit has no effect.
- R8: Matches are judged only on min_tick, so a flag cleared while the matching time is still present stays clear until the next matching strobe.
- R9: If a flag set and a write-0 clear of the same flag fall on the same edge, the set wins.
- R10: The weekly flag drives wk_alarm_n and the daily flag drives dy_alarm_n. The two channels can be low at the same time.
- R11: Register map (7-bit data): 0 weekly minute, 1 weekly hour, 2 weekly day mask, 3 daily minute, 4 daily hour, 5 enables (bit 0 weekly, bit 1 daily), 6 flags (bit 0 weekly, bit 1 daily). Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz clock |
| rst | input | 1 | Synchronous active-high reset |
| min_tick | input | 1 | One-cycle strobe when the minute changes |
| cur_min | input | 7 | Current minute, BCD |
| cur_hour | input | 6 | Current hour, BCD, format per mode_24h |
| cur_dow | input | 3 | Current day code, 0 to 6 |
| mode_24h | input | 1 | 1 selects 24-hour format, 0 selects 12-hour format |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address |
| wr_data | input | 7 | Write data |
| rd_addr | input | 3 | Read address |
| rd_data | output | 7 | Read data (combinational) |
| wk_alarm_n | output | 1 | Weekly alarm, active low |
| dy_alarm_n | output | 1 | Daily alarm, active low |

## Verification
A delayed flag set and a software write-0 clear of the same flag can land on the same clock edge. The bench provokes this by starting a matching minute strobe and then issuing the clearing write exactly two cycles later. It then expects the output to be low, because the new match must not be lost. A second coincidence, both channels matching on one strobe, is judged by expecting both outputs low and a flags readback of 3.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int MIN_W  = 7;
    localparam int HOUR_W = 6;
    localparam int DOW_W  = 3;
    localparam int DAYS   = 7;
    localparam int DATA_W = 7;
    localparam int ADDR_W = 3;
    localparam int NUM_CH = 2;
    localparam int KEY_W  = 6;

    localparam int CH_WK = 0;
    localparam int CH_DY = 1;

    typedef enum logic [ADDR_W-1:0] {
        A_WK_MIN  = 3'd0,
        A_WK_HOUR = 3'd1,
        A_WK_DAYS = 3'd2,
        A_DY_MIN  = 3'd3,
        A_DY_HOUR = 3'd4,
        A_CTRL    = 3'd5,
        A_FLAGS   = 3'd6
    } reg_addr_e;

    typedef struct packed {
        logic [MIN_W-1:0]  minute;
        logic [HOUR_W-1:0] hour;
        logic [DAYS-1:0]   days;
    } alarm_cfg_t;

    // Map a BCD hour in either format to a linear hour number 0..23.
    function automatic logic [KEY_W-1:0] hour_key(input logic [HOUR_W-1:0] h,
                                                  input logic mode24);
        logic [KEY_W-1:0] v;
        if (mode24) begin
            v = KEY_W'(h[5:4]) * KEY_W'(10) + KEY_W'(h[3:0]);
        end else begin
            v = (h[4] ? KEY_W'(10) : KEY_W'(0)) + KEY_W'(h[3:0]);
            if (v == KEY_W'(12)) v = '0;
            if (h[5]) v = v + KEY_W'(12);
        end
        return v;
    endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    input  logic [DATA_W-1:0]     wr_data,
    output alarm_cfg_t [NUM_CH-1:0] cfg,
    output logic [NUM_CH-1:0]     en_q,
    output logic [NUM_CH-1:0]     en_next
);

    logic [MIN_W-1:0]  wk_min_q, dy_min_q;
    logic [HOUR_W-1:0] wk_hour_q, dy_hour_q;
    logic [DAYS-1:0]   wk_days_q;

    assign en_next = (wr_en && wr_addr == A_CTRL) ? wr_data[NUM_CH-1:0] : en_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wk_min_q  <= '0;
            wk_hour_q <= '0;
            wk_days_q <= '0;
            dy_min_q  <= '0;
            dy_hour_q <= '0;
            en_q      <= '0;
        end else begin
            en_q <= en_next;
            if (wr_en) begin
                case (wr_addr)
                    A_WK_MIN:  wk_min_q  <= wr_data[MIN_W-1:0];
                    A_WK_HOUR: wk_hour_q <= wr_data[HOUR_W-1:0];
                    A_WK_DAYS: wk_days_q <= wr_data[DAYS-1:0];
                    A_DY_MIN:  dy_min_q  <= wr_data[MIN_W-1:0];
                    A_DY_HOUR: dy_hour_q <= wr_data[HOUR_W-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_comb begin
        cfg[CH_WK].minute = wk_min_q;
        cfg[CH_WK].hour   = wk_hour_q;
        cfg[CH_WK].days   = wk_days_q;
        cfg[CH_DY].minute = dy_min_q;
        cfg[CH_DY].hour   = dy_hour_q;
        cfg[CH_DY].days   = '1;
    end

endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
    import alarm_pkg::*;
(
    input  alarm_cfg_t        cfg,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [DOW_W-1:0]  cur_dow,
    input  logic              mode_24h,
    output logic              hit
);

    logic day_ok;
    logic hour_ok;

    always_comb begin
        day_ok = 1'b0;
        for (int d = 0; d < DAYS; d++) begin
            if (cur_dow == DOW_W'(d)) day_ok = cfg.days[d];
        end
        hour_ok = hour_key(cfg.hour, mode_24h) == hour_key(cur_hour, mode_24h);
        hit     = day_ok && hour_ok && (cfg.minute == cur_min);
    end

endmodule

// File: rtl/alarm_chan.sv
module alarm_chan #(
    parameter int SET_DLY = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic hit,
    input  logic en_next,
    input  logic clr,
    output logic flag,
    output logic set_req
);

    logic [SET_DLY-1:0] pipe;

    generate
        if (SET_DLY == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= tick & hit;
            end
        end else begin : g_shift
            always_ff @(posedge clk) begin
                if (rst) pipe <= '0;
                else     pipe <= {pipe[SET_DLY-2:0], tick & hit};
            end
        end
    endgenerate

    assign set_req = pipe[SET_DLY-1];

    always_ff @(posedge clk) begin
        if (rst)          flag <= 1'b0;
        else if (!en_next) flag <= 1'b0;
        else if (set_req) flag <= 1'b1;
        else if (clr)     flag <= 1'b0;
    end

endmodule

// File: rtl/alarm_matcher.sv
module alarm_matcher
    import alarm_pkg::*;
#(
    parameter int SET_DLY = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              min_tick,
    input  logic [MIN_W-1:0]  cur_min,
    input  logic [HOUR_W-1:0] cur_hour,
    input  logic [DOW_W-1:0]  cur_dow,
    input  logic              mode_24h,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              wk_alarm_n,
    output logic              dy_alarm_n
);

    alarm_cfg_t [NUM_CH-1:0] cfg;
    logic [NUM_CH-1:0] en_q;
    logic [NUM_CH-1:0] en_next;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] clr;
    logic [NUM_CH-1:0] flag;
    logic [NUM_CH-1:0] set_req;

    alarm_regs u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .cfg     (cfg),
        .en_q    (en_q),
        .en_next (en_next)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign clr[c] = wr_en && (wr_addr == A_FLAGS) && !wr_data[c];

        alarm_cmp u_cmp (
            .cfg      (cfg[c]),
            .cur_min  (cur_min),
            .cur_hour (cur_hour),
            .cur_dow  (cur_dow),
            .mode_24h (mode_24h),
            .hit      (hit[c])
        );

        alarm_chan #(.SET_DLY(SET_DLY)) u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (min_tick),
            .hit     (hit[c]),
            .en_next (en_next[c]),
            .clr     (clr[c]),
            .flag    (flag[c]),
            .set_req (set_req[c])
        );
    end

    assign wk_alarm_n = ~flag[CH_WK];
    assign dy_alarm_n = ~flag[CH_DY];

    always_comb begin
        case (rd_addr)
            A_WK_MIN:  rd_data = DATA_W'(cfg[CH_WK].minute);
            A_WK_HOUR: rd_data = DATA_W'(cfg[CH_WK].hour);
            A_WK_DAYS: rd_data = DATA_W'(cfg[CH_WK].days);
            A_DY_MIN:  rd_data = DATA_W'(cfg[CH_DY].minute);
            A_DY_HOUR: rd_data = DATA_W'(cfg[CH_DY].hour);
            A_CTRL:    rd_data = DATA_W'(en_q);
            A_FLAGS:   rd_data = DATA_W'(flag & en_q);
            default:   rd_data = '0;
        endcase
    end

endmodule

// File: rtl/alarm_matcher_chk.sv
module alarm_matcher_chk
    import alarm_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [1:0]        wr_bits,
    input logic              wk_alarm_n,
    input logic              dy_alarm_n,
    input logic [1:0]        en_q,
    input logic [1:0]        set_req
);

    logic flag_wr;
    assign flag_wr = wr_en && (wr_addr == A_FLAGS);

    p_wk_dis_r6: assert property (@(posedge clk) disable iff (rst)
        !en_q[0] |-> wk_alarm_n);
    p_dy_dis_r6: assert property (@(posedge clk) disable iff (rst)
        !en_q[1] |-> dy_alarm_n);

    p_wk_set_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(wk_alarm_n) |-> $past(set_req[0]));
    p_dy_set_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(dy_alarm_n) |-> $past(set_req[1]));

    p_wk_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && !wr_bits[0] && !set_req[0]) |=> wk_alarm_n);
    p_dy_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && !wr_bits[1] && !set_req[1]) |=> dy_alarm_n);

    p_wk_w1_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && wr_bits[0] && !set_req[0]) |=> $stable(wk_alarm_n));
    p_dy_w1_r7: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && wr_bits[1] && !set_req[1]) |=> $stable(dy_alarm_n));

    p_wk_prio_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && !wr_bits[0] && set_req[0] && en_q[0]) |=> !wk_alarm_n);
    p_dy_prio_r9: assert property (@(posedge clk) disable iff (rst)
        (flag_wr && !wr_bits[1] && set_req[1] && en_q[1]) |=> !dy_alarm_n);

endmodule

bind alarm_matcher alarm_matcher_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .wr_addr    (wr_addr),
    .wr_bits    (wr_data[1:0]),
    .wk_alarm_n (wk_alarm_n),
    .dy_alarm_n (dy_alarm_n),
    .en_q       (en_q),
    .set_req    (set_req)
);

// File: tb/alarm_matcher_tb.sv
module alarm_matcher_tb;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       min_tick = 1'b0;
    logic [6:0] cur_min = '0;
    logic [5:0] cur_hour = '0;
    logic [2:0] cur_dow = '0;
    logic       mode_24h = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [6:0] wr_data = '0;
    logic [2:0] rd_addr = 3'd6;
    logic [6:0] rd_data;
    logic       wk_alarm_n;
    logic       dy_alarm_n;

    alarm_matcher u_dut (
        .clk(clk), .rst(rst), .min_tick(min_tick), .cur_min(cur_min),
        .cur_hour(cur_hour), .cur_dow(cur_dow), .mode_24h(mode_24h),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wk_alarm_n(wk_alarm_n), .dy_alarm_n(dy_alarm_n)
    );

    always #(CLK_P/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        int         due;
        logic       wk;
        logic       dy;
        logic [6:0] rd;
        string      tag;
    } exp_t;

    exp_t sb[$];
    int   tests = 0;
    int   fails = 0;
    bit   done  = 0;

    // Monitor: compares scoreboard items whose cycle has come.
    initial forever begin
        @(negedge clk);
        #1;
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].due == cyc) begin
                tests++;
                if (wk_alarm_n !== sb[i].wk || dy_alarm_n !== sb[i].dy || rd_data !== sb[i].rd) begin
                    fails++;
                    $display("FAIL %s: actual wk=%b dy=%b rd=%h expected wk=%b dy=%b rd=%h",
                             sb[i].tag, wk_alarm_n, dy_alarm_n, rd_data,
                             sb[i].wk, sb[i].dy, sb[i].rd);
                end
                sb.delete(i);
            end
        end
    end

    task automatic nxt();
        @(negedge clk);
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_at(input int k, input logic wk, input logic dy,
                             input logic [6:0] rd, input string tag);
        exp_t e;
        e.due = cyc + k; e.wk = wk; e.dy = dy; e.rd = rd; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic wr(input logic [2:0] a, input logic [6:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        nxt();
        wr_en = 1'b0;
    endtask

    task automatic strobe(input logic [6:0] m, input logic [5:0] h, input logic [2:0] dw);
        cur_min = m; cur_hour = h; cur_dow = dw; min_tick = 1'b1;
        nxt();
        min_tick = 1'b0;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual run still busy expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        wait_n(3);
        rst = 1'b0;
        // R1: reset state
        expect_at(0, 1, 1, 7'h00, "R1 flags"); nxt();
        rd_addr = 3'd5; expect_at(0, 1, 1, 7'h00, "R1 ctrl"); nxt();
        rd_addr = 3'd2; expect_at(0, 1, 1, 7'h00, "R1 mask"); nxt();

        // R11: configuration and readback
        wr(3'd0, 7'h30);
        wr(3'd1, 7'h07);
        expect_at(1, 1, 1, 7'h15, "R11 mask readback");
        wr(3'd2, 7'h15);
        wr(3'd3, 7'h15);
        wr(3'd4, 7'h22);
        wr(3'd5, 7'h03);
        rd_addr = 3'd6;

        // R5 / R2: weekly match on day 2, timing of the set
        expect_at(2, 1, 1, 7'h00, "R5 not yet");
        expect_at(3, 0, 1, 7'h01, "R2 weekly day2");
        strobe(7'h30, 7'h07, 3'd2); wait_n(2);

        // R7 clear, R8 no re-set within the same minute
        expect_at(1, 1, 1, 7'h00, "R7 clear");
        wr(3'd6, 7'h02);
        wait_n(5);
        expect_at(0, 1, 1, 7'h00, "R8 hold clear"); nxt();

        // R7 write 1 has no effect
        expect_at(3, 0, 1, 7'h01, "R2 weekly day4");
        strobe(7'h30, 7'h07, 3'd4); wait_n(2);
        expect_at(1, 0, 1, 7'h01, "R7 write1");
        wr(3'd6, 7'h03);
        expect_at(1, 1, 1, 7'h00, "R7 clear2");
        wr(3'd6, 7'h00);

        // R2 negatives
        expect_at(3, 1, 1, 7'h00, "R2 day1 off");
        strobe(7'h30, 7'h07, 3'd1); wait_n(2);
        expect_at(3, 1, 1, 7'h00, "R2 day6 off");
        strobe(7'h30, 7'h07, 3'd6); wait_n(2);
        expect_at(3, 1, 1, 7'h00, "R2 minute off");
        strobe(7'h31, 7'h07, 3'd0); wait_n(2);

        // R3 daily
        expect_at(3, 1, 0, 7'h02, "R3 daily day5");
        strobe(7'h15, 7'h22, 3'd5); wait_n(2);
        expect_at(1, 1, 1, 7'h00, "R7 clear daily");
        wr(3'd6, 7'h00);
        expect_at(3, 1, 0, 7'h02, "R3 daily day3");
        strobe(7'h15, 7'h22, 3'd3); wait_n(2);
        expect_at(3, 1, 0, 7'h02, "R3 minute off");
        strobe(7'h16, 7'h22, 3'd3); wait_n(2);

        // R6 enable
        expect_at(1, 1, 1, 7'h00, "R6 disable clears");
        wr(3'd5, 7'h01);
        expect_at(3, 1, 1, 7'h00, "R6 no set disabled");
        strobe(7'h15, 7'h22, 3'd1); wait_n(2);
        expect_at(1, 1, 1, 7'h00, "R6 reenable");
        wr(3'd5, 7'h03);

        // R10 both channels
        wr(3'd0, 7'h15);
        wr(3'd1, 7'h22);
        expect_at(3, 0, 0, 7'h03, "R10 both low");
        strobe(7'h15, 7'h22, 3'd0); wait_n(2);
        expect_at(1, 1, 1, 7'h00, "R7 clear both");
        wr(3'd6, 7'h00);

        // R9 set beats simultaneous clear
        expect_at(3, 0, 0, 7'h03, "R9 set wins");
        strobe(7'h15, 7'h22, 3'd2); nxt();
        wr(3'd6, 7'h00);
        expect_at(1, 1, 1, 7'h00, "R7 clear after R9");
        wr(3'd6, 7'h00);

        // R4 12-hour format
        mode_24h = 1'b0;
        wr(3'd0, 7'h00);
        wr(3'd1, 7'h12);
        wr(3'd2, 7'h7F);
        wr(3'd3, 7'h45);
        wr(3'd4, 7'h31);
        expect_at(3, 1, 1, 7'h00, "R4 12PM vs 12AM");
        strobe(7'h00, 7'h32, 3'd3); wait_n(2);
        expect_at(3, 0, 1, 7'h01, "R4 12AM match");
        strobe(7'h00, 7'h12, 3'd3); wait_n(2);
        expect_at(3, 0, 1, 7'h01, "R4 11AM vs 11PM");
        strobe(7'h45, 7'h11, 3'd3); wait_n(2);
        expect_at(3, 0, 0, 7'h03, "R4 11PM match");
        strobe(7'h45, 7'h31, 3'd3); wait_n(2);

        wait_n(3);
        if (sb.size() != 0) begin
            fails++;
            $display("FAIL scoreboard: actual %0d pending expected 0", sb.size());
        end
        done = 1;
        summary();
        $finish;
    end

endmodule